// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it may take one operation, a byte from the file register (`f_data`) and the contents of its own working register. It produces the result and five status flags: negative, signed overflow, zero, nibble carry and carry. The working register and the flag register are held inside the block.

A destination bit chooses where the result goes. With the bit clear, the working register is overwritten. With it set, the result leaves the block on a one-cycle write strobe so that the file register can store it.

For subtraction, the carry and nibble-carry flags hold the inverse of a borrow. The borrow-consuming forms take the inverse of the stored carry as their borrow input, and both operand orders are offered. The two rotates pass through the carry flag.

Top module: `alu_status_unit`

## Requirements
- R1: While `rst_n` is low, the working register, the flag register, `f_wr_en` and `f_wr_data` are all cleared to zero on each clock edge.
- R2: An accepted operation shows its effect on the outputs right after the clock edge that takes it. `flags_out` is {N, OV, Z, DC, C} from bit 4 down to bit 0. After every executed operation, N equals bit 7 of the result and Z is 1 exactly when the 8-bit result is zero.
- R3: Code 0 (add) gives f + W. Code 1 (add with carry) gives f + W + C. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R4: OV is set by every arithmetic code (0 to 5) exactly when the two's-complement result is out of the signed 8-bit range.
- R5: Code 2 gives f − W and code 4 gives W − f. C and DC hold the inverse of the borrow out of bit 7 and bit 3, so 1 means no borrow occurred.
- R6: Code 3 gives f − W − B and code 5 gives W − f − B, where the borrow B is the inverse of the stored C. C and DC follow the same inverted-borrow rule as R5.
- R7: Codes 6 (AND), 7 (OR), 8 (XOR) and 9 (move f) update only N and Z. C, DC and OV keep their values.
- R8: Code 10 rotates f right through carry: the old C enters bit 7 and bit 0 goes to C. Code 11 rotates f left through carry: the old C enters bit 0 and bit 7 goes to C. N and Z are updated. DC and OV are unchanged.
- R9: With `dest` at 0, the result replaces the working register and `f_wr_en` stays low. With `dest` at 1, `f_wr_en` is high for one cycle, `f_wr_data` carries the result, and the working register is unchanged.
- R10: When `op_valid` is low, or when the code is in the reserved range 12 to 15, the working register and the flags do not change and `f_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code, see R3 to R10 |
| dest | input | 1 | 0 sends the result to the working register, 1 sends it to the file write port |
| f_data | input | WIDTH | File register operand |
| wreg_out | output | WIDTH | Working register contents |
| flags_out | output | 5 | {N, OV, Z, DC, C} |
| f_wr_en | output | 1 | One-cycle write strobe toward the file register |
| f_wr_data | output | WIDTH | Result to be written to the file register |

## Verification
The bench builds the block with its defaults: WIDTH of 8 and a nibble boundary at 4. At that width, random byte operands readily cross the signed limits 0x7F/0x80 and the nibble edge 0x0F/0x10. That exercises OV, DC and the inverted-borrow sense in both subtract orders with only a few thousand operations. A reference model that works in plain integers (signed range tests, negative differences) is compared against the ports every cycle. Directed sequences first chain the carry through the rotates into the borrow forms, then show that the logic codes and the reserved codes leave the untouched flags in place.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBB  = 4'd3,
        OP_RSUB  = 4'd4,
        OP_RSUBB = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_MOVE  = 4'd9,
        OP_RRC   = 4'd10,
        OP_RLC   = 4'd11
    } op_e;

    localparam logic [3:0] OP_LAST = 4'd11;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] f_val,
    input  logic [WIDTH-1:0] w_val,
    input  logic             c_flag,
    output logic [WIDTH-1:0] x_opnd,
    output logic [WIDTH-1:0] y_opnd,
    output logic             carry_in,
    output logic             is_arith,
    output logic             is_legal
);

    always_comb begin
        x_opnd   = f_val;
        y_opnd   = w_val;
        carry_in = 1'b0;
        is_arith = 1'b1;
        is_legal = (op <= OP_LAST);
        unique case (op)
            OP_ADD:   ;
            OP_ADDC:  carry_in = c_flag;
            OP_SUB: begin
                y_opnd   = ~w_val;
                carry_in = 1'b1;
            end
            OP_SUBB: begin
                y_opnd   = ~w_val;
                carry_in = c_flag;
            end
            OP_RSUB: begin
                x_opnd   = w_val;
                y_opnd   = ~f_val;
                carry_in = 1'b1;
            end
            OP_RSUBB: begin
                x_opnd   = w_val;
                y_opnd   = ~f_val;
                carry_in = c_flag;
            end
            default:  is_arith = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic [WIDTH-1:0] x_opnd,
    input  logic [WIDTH-1:0] y_opnd,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             digit_carry,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full_sum;

    assign full_sum  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{WIDTH{1'b0}}, carry_in};
    assign sum       = full_sum[MSB:0];
    assign carry_out = full_sum[WIDTH];
    assign overflow  = (x_opnd[MSB] == y_opnd[MSB]) && (full_sum[MSB] != x_opnd[MSB]);

    generate
        if (DIGIT > 0 && DIGIT < WIDTH) begin : g_digit
            logic [DIGIT:0] low_sum;
            assign low_sum     = {1'b0, x_opnd[DIGIT-1:0]} + {1'b0, y_opnd[DIGIT-1:0]}
                               + {{DIGIT{1'b0}}, carry_in};
            assign digit_carry = low_sum[DIGIT];
        end else begin : g_no_digit
            assign digit_carry = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] f_val,
    input  logic [WIDTH-1:0] w_val,
    input  logic             c_flag,
    output logic [WIDTH-1:0] result,
    output logic             shift_out,
    output logic             is_rotate
);

    always_comb begin
        result    = f_val;
        shift_out = c_flag;
        is_rotate = 1'b0;
        case (op)
            OP_AND:  result = f_val & w_val;
            OP_OR:   result = f_val | w_val;
            OP_XOR:  result = f_val ^ w_val;
            OP_RRC: begin
                result    = {c_flag, f_val[WIDTH-1:1]};
                shift_out = f_val[0];
                is_rotate = 1'b1;
            end
            OP_RLC: begin
                result    = {f_val[WIDTH-2:0], c_flag};
                shift_out = f_val[WIDTH-1];
                is_rotate = 1'b1;
            end
            default: result = f_val;
        endcase
    end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic             dest,
    input  logic [WIDTH-1:0] f_data,
    output logic [WIDTH-1:0] wreg_out,
    output logic [4:0]       flags_out,
    output logic             f_wr_en,
    output logic [WIDTH-1:0] f_wr_data
);

    typedef struct packed {
        logic [WIDTH-1:0] wreg;
        flags_t           flags;
        logic             wr_en;
        logic [WIDTH-1:0] wr_data;
    } state_t;

    state_t st_d, st_q;

    op_e              op;
    logic [WIDTH-1:0] x_opnd, y_opnd, add_sum, logic_res, result;
    logic             carry_in, is_arith, is_legal;
    logic             add_c, add_dc, add_ov;
    logic             shift_out, is_rotate;

    assign op = op_e'(op_code);

    alu_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .op       (op),
        .f_val    (f_data),
        .w_val    (st_q.wreg),
        .c_flag   (st_q.flags.c),
        .x_opnd   (x_opnd),
        .y_opnd   (y_opnd),
        .carry_in (carry_in),
        .is_arith (is_arith),
        .is_legal (is_legal)
    );

    alu_adder #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_add (
        .x_opnd      (x_opnd),
        .y_opnd      (y_opnd),
        .carry_in    (carry_in),
        .sum         (add_sum),
        .carry_out   (add_c),
        .digit_carry (add_dc),
        .overflow    (add_ov)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .op        (op),
        .f_val     (f_data),
        .w_val     (st_q.wreg),
        .c_flag    (st_q.flags.c),
        .result    (logic_res),
        .shift_out (shift_out),
        .is_rotate (is_rotate)
    );

    assign result = is_arith ? add_sum : logic_res;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (op_valid && is_legal) begin
            st_d.flags.n = result[WIDTH-1];
            st_d.flags.z = (result == '0);
            if (is_arith) begin
                st_d.flags.c  = add_c;
                st_d.flags.dc = add_dc;
                st_d.flags.ov = add_ov;
            end else if (is_rotate) begin
                st_d.flags.c = shift_out;
            end
            if (dest) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_data = result;
            end else begin
                st_d.wreg = result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wreg_out  = st_q.wreg;
    assign flags_out = st_q.flags;
    assign f_wr_en   = st_q.wr_en;
    assign f_wr_data = st_q.wr_data;

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic             dest,
    input logic [WIDTH-1:0] f_data,
    input logic [WIDTH-1:0] wreg_out,
    input logic [4:0]       flags_out,
    input logic             f_wr_en,
    input logic [WIDTH-1:0] f_wr_data
);

    logic exec;
    assign exec = op_valid && (op_code <= 4'd11);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (wreg_out == '0) && (flags_out == '0) && !f_wr_en);

    a_r2_nz_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        f_wr_en |-> (flags_out[4] == f_wr_data[WIDTH-1]) && (flags_out[2] == (f_wr_data == '0)));

    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0 && dest)
        |=> {flags_out[0], f_wr_data} == ({1'b0, $past(f_data)} + {1'b0, $past(wreg_out)}));

    a_r5_sub_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2 && dest)
        |=> flags_out[0] == ($past(f_data) >= $past(wreg_out)));

    a_r7_logic_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd6 && op_code <= 4'd9)
        |=> $stable({flags_out[3], flags_out[1:0]}));

    a_r8_rrc_file: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd10 && dest)
        |=> (flags_out[0] == $past(f_data[0]))
            && (f_wr_data == {$past(flags_out[0]), $past(f_data[WIDTH-1:1])}));

    a_r9_dest_file: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dest) |=> f_wr_en && $stable(wreg_out));

    a_r9_dest_wreg: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !dest) |=> !f_wr_en);

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> !f_wr_en && $stable(wreg_out) && $stable(flags_out));

endmodule

bind alu_status_unit alu_status_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .dest      (dest),
    .f_data    (f_data),
    .wreg_out  (wreg_out),
    .flags_out (flags_out),
    .f_wr_en   (f_wr_en),
    .f_wr_data (f_wr_data)
);

// File: tb/alu_status_unit_tb.sv
module alu_status_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int WDOG_LIMIT = 50000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [3:0]       op_code = 4'd0;
    logic             dest = 1'b0;
    logic [WIDTH-1:0] f_data = '0;
    logic [WIDTH-1:0] wreg_out;
    logic [4:0]       flags_out;
    logic             f_wr_en;
    logic [WIDTH-1:0] f_wr_data;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  started = 0;
    bit  reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_status_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .dest      (dest),
        .f_data    (f_data),
        .wreg_out  (wreg_out),
        .flags_out (flags_out),
        .f_wr_en   (f_wr_en),
        .f_wr_data (f_wr_data)
    );

    // behavioural reference model, integer arithmetic
    int    m_w, m_we, m_wd;
    bit    m_n, m_ov, m_z, m_dc, m_c;
    string m_tag = "R1";

    function automatic int sgn(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    always @(posedge clk) begin
        int f, w, r, s, lo, bor;
        string tag;
        started <= 1'b1;
        if (!rst_n) begin
            m_w <= 0; m_we <= 0; m_wd <= 0;
            {m_n, m_ov, m_z, m_dc, m_c} <= 5'b0;
            m_tag <= "R1";
        end else begin
            m_we <= 0;
            tag = "R10";
            if (op_valid && op_code <= 11) begin
                f = int'(f_data); w = m_w; bor = m_c ? 0 : 1;
                r = 0;
                case (op_code)
                    0, 1: begin
                        s  = (op_code == 1) ? int'(m_c) : 0;
                        r  = f + w + s;
                        lo = (f % 16) + (w % 16) + s;
                        m_c <= (r > 255); m_dc <= (lo > 15);
                        m_ov <= (sgn(f) + sgn(w) + s > 127) || (sgn(f) + sgn(w) + s < -128);
                        tag = "R3";
                    end
                    2, 3, 4, 5: begin
                        s = (op_code == 3 || op_code == 5) ? bor : 0;
                        if (op_code >= 4) begin r = w; w = f; f = r; end
                        r  = f - w - s;
                        lo = (f % 16) - (w % 16) - s;
                        m_c <= (r >= 0); m_dc <= (lo >= 0);
                        m_ov <= (sgn(f) - sgn(w) - s > 127) || (sgn(f) - sgn(w) - s < -128);
                        if (r < 0) r = r + 256;
                        tag = (s != 0 || op_code == 3 || op_code == 5) ? "R6" : "R5";
                    end
                    6: begin r = f & w; tag = "R7"; end
                    7: begin r = f | w; tag = "R7"; end
                    8: begin r = f ^ w; tag = "R7"; end
                    9: begin r = f;     tag = "R7"; end
                    10: begin
                        r = (f / 2) + (m_c ? 128 : 0);
                        m_c <= (f % 2 == 1); tag = "R8";
                    end
                    default: begin
                        r = ((f * 2) % 256) + (m_c ? 1 : 0);
                        m_c <= (f >= 128); tag = "R8";
                    end
                endcase
                r = r % 256;
                m_n <= (r >= 128); m_z <= (r == 0);
                if (dest) begin m_we <= 1; m_wd <= r; end
                else m_w <= r;
            end
            m_tag <= tag;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !reported) begin
            n_vec++;
            if (wreg_out !== m_w[7:0] ||
                flags_out !== {m_n, m_ov, m_z, m_dc, m_c} ||
                f_wr_en !== m_we[0] ||
                (m_we != 0 && f_wr_data !== m_wd[7:0])) begin
                n_bad++;
                $display("FAIL %s/R2/R9 model: w=%h fl=%b we=%b wd=%h expected w=%h fl=%b we=%0d wd=%h",
                         m_tag, wreg_out, flags_out, f_wr_en, f_wr_data,
                         m_w[7:0], {m_n, m_ov, m_z, m_dc, m_c}, m_we, m_wd[7:0]);
            end
        end
    end

    task automatic chk(string tag, logic [7:0] ew, logic [4:0] ef, logic ewe, logic [7:0] ewd);
        n_vec++;
        if (wreg_out !== ew || flags_out !== ef || f_wr_en !== ewe || (ewe && f_wr_data !== ewd)) begin
            n_bad++;
            $display("FAIL %s: w=%h fl=%b we=%b wd=%h expected w=%h fl=%b we=%b wd=%h",
                     tag, wreg_out, flags_out, f_wr_en, f_wr_data, ew, ef, ewe, ewd);
        end
    endtask

    task automatic do_op(logic [3:0] o, logic d, logic [7:0] f);
        op_valid = 1'b1; op_code = o; dest = d; f_data = f;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 8'h00, 5'b00000, 1'b0, 8'h00);
        rst_n = 1'b1;

        do_op(4'd9,  1'b0, 8'h7F); chk("R7 move",             8'h7F, 5'b00000, 1'b0, 8'h00);
        do_op(4'd0,  1'b0, 8'h01); chk("R3 R4 add ovf",       8'h80, 5'b11010, 1'b0, 8'h00);
        do_op(4'd0,  1'b1, 8'h80); chk("R3 R9 add to file",   8'h80, 5'b01101, 1'b1, 8'h00);
        do_op(4'd2,  1'b0, 8'h80); chk("R5 sub equal",        8'h00, 5'b00111, 1'b0, 8'h00);
        do_op(4'd6,  1'b0, 8'hFF); chk("R7 and keeps C DC",   8'h00, 5'b00111, 1'b0, 8'h00);
        do_op(4'd4,  1'b0, 8'h01); chk("R5 reverse sub",      8'hFF, 5'b10000, 1'b0, 8'h00);
        do_op(4'd3,  1'b1, 8'h10); chk("R6 sub with borrow",  8'hFF, 5'b00000, 1'b1, 8'h10);
        do_op(4'd10, 1'b0, 8'h01); chk("R8 rotate right",     8'h00, 5'b00101, 1'b0, 8'h00);
        do_op(4'd11, 1'b0, 8'h40); chk("R8 rotate left",      8'h81, 5'b10000, 1'b0, 8'h00);
        do_op(4'd13, 1'b1, 8'h55); chk("R10 reserved code",   8'h81, 5'b10000, 1'b0, 8'h00);
        @(negedge clk);            chk("R10 idle",            8'h81, 5'b10000, 1'b0, 8'h00);
        do_op(4'd10, 1'b1, 8'h01); chk("R8 R9 rotate to file",8'h81, 5'b00101, 1'b1, 8'h00);
        do_op(4'd1,  1'b0, 8'h7E); chk("R3 add with carry",   8'h00, 5'b00111, 1'b0, 8'h00);
        do_op(4'd9,  1'b0, 8'h80); chk("R7 move keeps C",     8'h80, 5'b10011, 1'b0, 8'h00);
        do_op(4'd5,  1'b0, 8'h01); chk("R6 R4 reverse borrow",8'h7F, 5'b01001, 1'b0, 8'h00);
        do_op(4'd8,  1'b1, 8'h7F); chk("R7 R2 xor zero",      8'h7F, 5'b01101, 1'b1, 8'h00);
        do_op(4'd7,  1'b0, 8'h80); chk("R7 or",               8'hFF, 5'b11001, 1'b0, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            op_valid = ($urandom_range(0, 7) != 0);
            op_code  = 4'($urandom_range(0, 15));
            dest     = 1'($urandom_range(0, 1));
            f_data   = 8'($urandom_range(0, 255));
            @(negedge clk);
        end
        op_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset again", 8'h00, 5'b00000, 1'b0, 8'h00);
        @(negedge clk);
        report();
        $finish;
    end

endmodule